// File: doc/BRIEF.md
# Width-Selectable Decimal/Binary Add-with-Carry Unit

This block is one arithmetic slice of a processor datapath. It adds an accumulator value, a memory operand and an incoming carry. A size input picks the width of the operation: 8 bits when it is high, 16 bits when it is low. A decimal input picks plain binary addition or packed-BCD addition. It produces the sum and four condition flags: carry, overflow, zero and negative.

In decimal mode each 4-bit digit is added together with the carry from the digit below it. Any digit whose sum goes past nine is corrected by six, and the carry moves up into the next digit. The correction runs from the lowest digit upward through two digits in 8-bit mode or four digits in 16-bit mode.

All flags are taken from the width in use. The outputs are registered by default, so a result appears one clock after the operands are presented with `in_valid`. A parameter also offers a purely combinational build.

Top module: `adc_width_unit`

## Requirements
- R1: With `size8`=1 only bits [7:0] take part in the operation, and `sum_out[15:8]` equals `acc_in[15:8]` unchanged. With `size8`=0 all 16 bits take part.
- R2: With `dec_mode`=0, `{carry_out, sum_out}` over the active width equals acc + operand + `carry_in`.
- R3: With `dec_mode`=1, each 4-bit digit is the sum of both operand digits plus the carry into that digit. When that sum exceeds 9, 6 is added to it, its low 4 bits become the result digit, and a carry goes to the next digit.
- R4: Decimal carries ripple from digit 0 (bits [3:0]) upward through digit 1 in 8-bit mode or digit 3 in 16-bit mode. `carry_out` is the carry out of the top active digit, which means the corrected result exceeded the width's maximum value.
- R5: `ovf_out` is 1 exactly when the operands have equal sign bits (bit 7 or bit 15) and the sign bit of the uncorrected sum differs from them. In decimal mode the sign is read before the correction of the top digit.
- R6: `zero_out` is 1 exactly when the active-width bits of the result are all zero.
- R7: `neg_out` equals bit 7 (8-bit mode) or bit 15 (16-bit mode) of the result.
- R8: With the registered build, results and `out_valid` appear one clock after `in_valid`. A synchronous reset clears every output to 0.
- R9: In a cycle without `in_valid`, `out_valid` drops to 0 in the next cycle and the result and flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| acc_in | input | 16 | Accumulator operand |
| opnd_in | input | 16 | Memory operand |
| carry_in | input | 1 | Incoming carry |
| size8 | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| dec_mode | input | 1 | 1 = packed-BCD, 0 = binary |
| out_valid | output | 1 | Result valid |
| sum_out | output | 16 | Result (upper byte is the accumulator's in 8-bit mode) |
| carry_out | output | 1 | Carry flag |
| ovf_out | output | 1 | Overflow flag |
| zero_out | output | 1 | Zero flag |
| neg_out | output | 1 | Negative flag |

## Verification
The digit-range assertion assumes that both operand digits are valid BCD (0 to 9) whenever decimal mode is on. It is only armed under that condition, so in decimal mode the directed stimulus uses only well-formed BCD operands. The clocked assertions assume that inputs stay free of X and are changed only between clock edges. The bench drives every input to a known value from time zero and changes inputs only on the falling edge.

// File: rtl/adc_pkg.sv
package adc_pkg;
  localparam int DIGIT_W   = 4;
  localparam int DEC_LIMIT = 9;
  localparam int DEC_ADJ   = 6;

  typedef struct packed {
    logic carry;
    logic ovf;
    logic zero;
    logic neg;
  } adc_flags_t;
endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
  import adc_pkg::*;
(
  input  logic [DIGIT_W-1:0] a_dig,
  input  logic [DIGIT_W-1:0] b_dig,
  input  logic               cin,
  input  logic               dec_en,
  output logic [DIGIT_W-1:0] dig_out,
  output logic               cout,
  output logic               raw_msb
);
  localparam int RAW_W = DIGIT_W + 2;

  logic [RAW_W-1:0] raw_sum;
  logic [RAW_W-1:0] adj_sum;
  logic             need_adj;

  always_comb begin
    raw_sum  = RAW_W'(a_dig) + RAW_W'(b_dig) + RAW_W'(cin);
    need_adj = dec_en && (raw_sum > RAW_W'(DEC_LIMIT));
    adj_sum  = need_adj ? raw_sum + RAW_W'(DEC_ADJ) : raw_sum;
    dig_out  = adj_sum[DIGIT_W-1:0];
    cout     = (adj_sum >= RAW_W'(1 << DIGIT_W));
    raw_msb  = raw_sum[DIGIT_W-1];
  end

  // valid BCD digits in decimal mode must yield a valid BCD digit
  always_comb begin
    if (dec_en && (a_dig <= DIGIT_W'(DEC_LIMIT)) && (b_dig <= DIGIT_W'(DEC_LIMIT)))
      AST_DIGIT_IN_RANGE: assert (dig_out <= DIGIT_W'(DEC_LIMIT)); // R3
  end
endmodule

// File: rtl/bcd_ripple_chain.sv
module bcd_ripple_chain
  import adc_pkg::*;
#(
  parameter int WIDE_W = 16
) (
  input  logic [WIDE_W-1:0]          a_val,
  input  logic [WIDE_W-1:0]          b_val,
  input  logic                       cin,
  input  logic                       dec_en,
  output logic [WIDE_W-1:0]          sum_val,
  output logic [WIDE_W/DIGIT_W-1:0]  dig_cout,
  output logic [WIDE_W/DIGIT_W-1:0]  dig_raw_msb
);
  localparam int DIGITS = WIDE_W / DIGIT_W;

  logic [DIGITS:0] carry_chain;
  assign carry_chain[0] = cin;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    bcd_digit_cell u_cell (
      .a_dig   (a_val[d*DIGIT_W +: DIGIT_W]),
      .b_dig   (b_val[d*DIGIT_W +: DIGIT_W]),
      .cin     (carry_chain[d]),
      .dec_en  (dec_en),
      .dig_out (sum_val[d*DIGIT_W +: DIGIT_W]),
      .cout    (carry_chain[d+1]),
      .raw_msb (dig_raw_msb[d])
    );
    assign dig_cout[d] = carry_chain[d+1];
  end
endmodule

// File: rtl/adc_flag_unit.sv
module adc_flag_unit
  import adc_pkg::*;
#(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic [WIDE_W-1:0]         a_val,
  input  logic [WIDE_W-1:0]         b_val,
  input  logic [WIDE_W-1:0]         sum_val,
  input  logic [WIDE_W/DIGIT_W-1:0] dig_cout,
  input  logic [WIDE_W/DIGIT_W-1:0] dig_raw_msb,
  input  logic                      narrow,
  output logic [WIDE_W-1:0]         result,
  output adc_flags_t                flags
);
  localparam int TOP_W = WIDE_W / DIGIT_W - 1;
  localparam int TOP_N = NARROW_W / DIGIT_W - 1;

  logic a_sign, b_sign, pre_sign;

  always_comb begin
    a_sign   = narrow ? a_val[NARROW_W-1]  : a_val[WIDE_W-1];
    b_sign   = narrow ? b_val[NARROW_W-1]  : b_val[WIDE_W-1];
    pre_sign = narrow ? dig_raw_msb[TOP_N] : dig_raw_msb[TOP_W];
    result   = narrow ? {a_val[WIDE_W-1:NARROW_W], sum_val[NARROW_W-1:0]} : sum_val;
    flags.carry = narrow ? dig_cout[TOP_N] : dig_cout[TOP_W];
    flags.ovf   = (a_sign == b_sign) && (pre_sign != a_sign);
    flags.zero  = narrow ? (result[NARROW_W-1:0] == '0) : (result == '0);
    flags.neg   = narrow ? result[NARROW_W-1] : result[WIDE_W-1];
  end

  always_comb begin
    if (narrow === 1'b1)
      AST_UPPER_PASS: assert (result[WIDE_W-1:NARROW_W] == a_val[WIDE_W-1:NARROW_W]); // R1
  end
endmodule

// File: rtl/adc_width_unit.sv
module adc_width_unit
  import adc_pkg::*;
#(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8,
  parameter bit REG_OUT  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WIDE_W-1:0] acc_in,
  input  logic [WIDE_W-1:0] opnd_in,
  input  logic              carry_in,
  input  logic              size8,
  input  logic              dec_mode,
  output logic              out_valid,
  output logic [WIDE_W-1:0] sum_out,
  output logic              carry_out,
  output logic              ovf_out,
  output logic              zero_out,
  output logic              neg_out
);
  localparam int DIGITS = WIDE_W / DIGIT_W;

  logic [WIDE_W-1:0] chain_sum;
  logic [DIGITS-1:0] chain_cout;
  logic [DIGITS-1:0] chain_msb;
  logic [WIDE_W-1:0] comb_result;
  adc_flags_t        comb_flags;

  bcd_ripple_chain #(.WIDE_W(WIDE_W)) u_chain (
    .a_val       (acc_in),
    .b_val       (opnd_in),
    .cin         (carry_in),
    .dec_en      (dec_mode),
    .sum_val     (chain_sum),
    .dig_cout    (chain_cout),
    .dig_raw_msb (chain_msb)
  );

  adc_flag_unit #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_flags (
    .a_val       (acc_in),
    .b_val       (opnd_in),
    .sum_val     (chain_sum),
    .dig_cout    (chain_cout),
    .dig_raw_msb (chain_msb),
    .narrow      (size8),
    .result      (comb_result),
    .flags       (comb_flags)
  );

  if (REG_OUT) begin : g_reg
    logic              vld_q;
    logic [WIDE_W-1:0] sum_q;
    adc_flags_t        flg_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= 1'b0;
        sum_q <= '0;
        flg_q <= '0;
      end else begin
        vld_q <= in_valid;
        if (in_valid) begin
          sum_q <= comb_result;
          flg_q <= comb_flags;
        end
      end
    end

    assign out_valid = vld_q;
    assign sum_out   = sum_q;
    assign carry_out = flg_q.carry;
    assign ovf_out   = flg_q.ovf;
    assign zero_out  = flg_q.zero;
    assign neg_out   = flg_q.neg;

    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
      in_valid && size8 |=> sum_out[WIDE_W-1:NARROW_W] == $past(acc_in[WIDE_W-1:NARROW_W])); // R1
    AST_BIN_SUM: assert property (@(posedge clk) disable iff (rst)
      in_valid && !dec_mode && !size8 |=>
        {carry_out, sum_out} == ({1'b0, $past(acc_in)} + {1'b0, $past(opnd_in)}
                                 + (WIDE_W+1)'($past(carry_in)))); // R2
    AST_BIN_OVF: assert property (@(posedge clk) disable iff (rst)
      in_valid && !dec_mode && !size8 && (acc_in[WIDE_W-1] == opnd_in[WIDE_W-1]) |=>
        ovf_out == (sum_out[WIDE_W-1] != $past(acc_in[WIDE_W-1]))); // R5
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> zero_out == ($past(size8) ? (sum_out[NARROW_W-1:0] == '0) : (sum_out == '0))); // R6
    AST_NEG_FLAG: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> neg_out == ($past(size8) ? sum_out[NARROW_W-1] : sum_out[WIDE_W-1])); // R7
    AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid && $stable(sum_out) && $stable(carry_out) && $stable(zero_out)); // R9
  end else begin : g_comb
    assign out_valid = in_valid;
    assign sum_out   = comb_result;
    assign carry_out = comb_flags.carry;
    assign ovf_out   = comb_flags.ovf;
    assign zero_out  = comb_flags.zero;
    assign neg_out   = comb_flags.neg;
  end
endmodule

// File: tb/adc_width_unit_tb.sv
module adc_width_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] acc_in = '0;
  logic [15:0] opnd_in = '0;
  logic        carry_in = 1'b0;
  logic        size8 = 1'b0;
  logic        dec_mode = 1'b0;
  logic        out_valid;
  logic [15:0] sum_out;
  logic        carry_out, ovf_out, zero_out, neg_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  adc_width_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .acc_in(acc_in), .opnd_in(opnd_in),
    .carry_in(carry_in), .size8(size8), .dec_mode(dec_mode), .out_valid(out_valid),
    .sum_out(sum_out), .carry_out(carry_out), .ovf_out(ovf_out), .zero_out(zero_out),
    .neg_out(neg_out)
  );

  // reference: {sum[15:0], c, v, z, n}
  function automatic logic [19:0] ref_model(input logic [15:0] a, input logic [15:0] b,
                                            input logic ci, input logic n8, input logic dec);
    logic [15:0] res;
    int ndig, s, cy, sgn, asg, bsg;
    logic z, n, v;
    res  = a;
    ndig = n8 ? 2 : 4;
    cy   = ci;
    sgn  = 0;
    for (int i = 0; i < ndig; i++) begin
      s = int'(a[i*4 +: 4]) + int'(b[i*4 +: 4]) + cy;
      if (i == ndig - 1) sgn = (s >> 3) & 1;
      if (dec && s > 9) s = s + 6;
      cy = (s > 15) ? 1 : 0;
      res[i*4 +: 4] = 4'(s & 15);
    end
    asg = n8 ? a[7] : a[15];
    bsg = n8 ? b[7] : b[15];
    v = (asg == bsg) && (sgn != asg);
    z = n8 ? (res[7:0] == 0) : (res == 0);
    n = n8 ? res[7] : res[15];
    return {res, 1'(cy), v, z, n};
  endfunction

  task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual sum=%h c=%b v=%b z=%b n=%b expected sum=%h c=%b v=%b z=%b n=%b",
               tag, act[19:4], act[3], act[2], act[1], act[0], exp[19:4], exp[3], exp[2], exp[1], exp[0]);
    end
  endtask

  function automatic logic [19:0] outs();
    return {sum_out, carry_out, ovf_out, zero_out, neg_out};
  endfunction

  // one operation: drive at negedge, registered result sampled one negedge later
  task automatic run_op(input string tag, input logic [15:0] a, input logic [15:0] b,
                        input logic ci, input logic n8, input logic dec);
    @(negedge clk);
    acc_in = a; opnd_in = b; carry_in = ci; size8 = n8; dec_mode = dec; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b1) begin
      fails++;
      $display("FAIL R8 %s: out_valid actual=%b expected=1", tag, out_valid);
    end
    check(tag, outs(), ref_model(a, b, ci, n8, dec));
  endtask

  task automatic t_reset();
    checks++;
    if ({out_valid, outs()} !== 21'd0) begin
      fails++;
      $display("FAIL R8 reset: actual=%h expected=0", {out_valid, outs()});
    end
  endtask

  task automatic t_binary();
    run_op("R2 bin16 basic", 16'h1234, 16'h4321, 1'b0, 1'b0, 1'b0);
    check("R2 bin16 hand", outs(), {16'h5555, 4'b0000});
    run_op("R2 bin16 carry wrap", 16'hFFFF, 16'h0000, 1'b1, 1'b0, 1'b0);
    check("R2 R6 bin16 wrap hand", outs(), {16'h0000, 4'b1010});
    run_op("R1 R2 bin8", 16'hAB7F, 16'hCD01, 1'b0, 1'b1, 1'b0);
    check("R1 R5 R7 bin8 hand", outs(), {16'hAB80, 4'b0101});
    run_op("R4 bin8 carry out", 16'h00FF, 16'h0001, 1'b0, 1'b1, 1'b0);
    check("R1 R6 bin8 zero hand", outs(), {16'h0000, 4'b1010});
  endtask

  task automatic t_decimal();
    run_op("R3 dec8 simple", 16'h0045, 16'h0038, 1'b0, 1'b1, 1'b1);
    check("R3 dec8 hand", outs(), {16'h0083, 4'b0001 | {1'b0, 1'b1, 2'b01} & 4'b0101});
    run_op("R4 dec8 full carry", 16'h5599, 16'h0001, 1'b0, 1'b1, 1'b1);
    check("R1 R4 R6 dec8 hand", outs(), {16'h5500, 4'b1010});
    run_op("R3 R5 dec8 ovf", 16'h0058, 16'h0046, 1'b1, 1'b1, 1'b1);
    check("R5 dec8 hand", outs(), {16'h0005, 4'b1100});
    run_op("R4 dec16 ripple", 16'h1234, 16'h8766, 1'b0, 1'b0, 1'b1);
    check("R4 R6 dec16 hand", outs(), {16'h0000, 4'b1010});
    run_op("R4 dec16 no wrap", 16'h0999, 16'h0001, 1'b0, 1'b0, 1'b1);
    check("R4 dec16 mid", outs(), {16'h1000, 4'b0000});
  endtask

  task automatic t_hold();
    logic [19:0] prev;
    prev = outs();
    @(negedge clk);
    acc_in = 16'h7777; opnd_in = 16'h1111; carry_in = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R9 out_valid actual=%b expected=0", out_valid);
    end
    check("R9 hold", outs(), prev);
  endtask

  task automatic t_sweep();
    logic [15:0] lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      logic [15:0] a, b;
      logic dec, n8, ci;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = lfsr;
      dec = k[0]; n8 = k[1]; ci = k[2];
      if (dec) begin
        for (int d = 0; d < 4; d++) begin
          a[d*4 +: 4] = 4'(a[d*4 +: 4] % 10);
          b[d*4 +: 4] = 4'(b[d*4 +: 4] % 10);
        end
      end
      run_op(dec ? "R3 R4 R5 dec sweep" : "R2 R5 bin sweep", a, b, ci, n8, dec);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_binary();
    t_decimal();
    t_hold();
    t_sweep();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    t_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule